// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Engine

This block models the device side of a byte-addressed serial EEPROM attached to an SPI bus. The bus pins (chip select, serial clock, serial data in and a pause input) are brought into the system clock domain through a short synchronizer. The block then decodes an eight-bit instruction and carries out sequential array reads, status reads, setting and clearing of a write-enable latch, and single-byte writes into an internal byte array whose depth is set by a parameter. The serial data output is delivered as a data bit plus an output-enable, so the pad ring can build the tristate buffer.

A committed byte write starts an internal busy interval. A down-counter on the system clock times this interval, and while it runs only the status read is honoured. Both SPI clock polarities with sample-on-rise and shift-on-fall are accepted. The serial clock must stay at each level for at least three system clock cycles so that the synchronizer can see every edge.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the output enable `so_oe` is low, the write-enable latch is clear and no write is in progress, so a status read returns 0x00.
- R2: The first eight bits after `cs_n` falls form the instruction, most significant bit first. Any byte other than 0x03, 0x02, 0x05, 0x06 or 0x04 is ignored, and `so_oe` stays low until `cs_n` rises.
- R3: Instruction 0x03 is followed by a 16-bit address, most significant bit first, of which only the low ADDR_BITS bits select a byte. The stored byte appears on `so`, most significant bit first, with its first bit driven on the falling edge of `sck` right after the last address bit.
- R4: During a read the byte pointer advances after each byte, wraps from the highest address to zero, and the read goes on for as long as `sck` runs.
- R5: Once `cs_n` is high, `so_oe` goes low within SYNC_STAGES+2 system clock cycles and any transfer in flight is abandoned.
- R6: Instruction 0x05 returns the status byte, repeated for as long as clocks arrive. Bit 0 is the busy flag (1 while a write cycle runs) and bit 1 is the write-enable latch; all other bits are 0. It is honoured during a write cycle.
- R7: Instruction 0x06 sets the write-enable latch and 0x04 clears it. A write instruction received while the latch is clear changes neither the array nor the busy flag.
- R8: Instruction 0x02 followed by a 16-bit address and one data byte stores that byte only if `cs_n` rises after exactly 32 `sck` rising edges. A frame with any other bit count stores nothing. A committed write clears the latch and holds the busy flag for WR_CYCLES system clock cycles.
- R9: While the busy flag is set, read, write, 0x06 and 0x04 instructions are ignored and `so_oe` stays low for them.
- R10: With `cs_n` low, pulling `hold_n` low while `sck` is low pauses the transfer: `so_oe` is low and `sck` and `si` edges are ignored. Raising `hold_n` while `sck` is low resumes the transfer exactly where it stopped.
- R11: Frames that start with `sck` idle low and frames that start with `sck` idle high behave the same; `si` is sampled on rising edges and `so` changes on falling edges in both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
Every array location is written with a distinct arithmetic pattern, using address words whose upper bits are filled with junk. A read is then started at each of the sixteen locations and run past the top of the array, so a pointer that does not wrap, or that decodes the upper address bits, shows up as a wrong byte. All 251 unused instruction bytes are swept to show that none of them drives the output. Write frames with seven and nine data bits, writes sent with the latch clear, and commands issued during a busy interval show that only correctly framed writes with the latch set reach the array. A read paused by the hold input, with `sck` and `si` toggled during the pause, must give the same bytes as an uninterrupted read. Frames alternate between the two clock idle levels.

// File: rtl/spi_eeprom_pkg.sv
// Shared instruction codes and state encodings for the serial EEPROM slave.
package spi_eeprom_pkg;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_RDST  = 8'h05;
    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;

    // Phase of the current chip-select frame.
    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_OUT,
        ST_SKIP
    } xfer_state_t;

    // Which instruction owns the frame.
    typedef enum logic [1:0] {
        K_NONE,
        K_READ,
        K_WRITE,
        K_STAT
    } xfer_kind_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each pin is held for longer than STAGES system clock cycles.
module spi_pin_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Each stage takes the previous one (or the pins) each cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else if (g == 0) stg[g] <= din;
                else stg[g] <= stg[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_eeprom_array.sv
// Byte storage with one synchronous write port and one combinational read port.
// Assumes contents are undefined until written; no reset on the storage.
module spi_eeprom_array #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;
    logic [7:0] mem [DEPTH];

    // Store one byte when the write strobe is present.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_eeprom_wtimer.sv
// Busy-interval timer: a start pulse holds busy high for CYCLES clocks.
// Assumes start is not re-issued while busy is high.
module spi_eeprom_wtimer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] remain;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) remain <= '0;
        else if (start) remain <= CW'(CYCLES);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/spi_eeprom_slave.sv
// Serial EEPROM slave engine: decodes instructions from the SPI pins,
// serves array and status reads, manages the write-enable latch and commits
// single-byte writes on chip-select release.
// Assumes sck stays at each level for at least SYNC_STAGES+1 clk cycles.
module spi_eeprom_slave
    import spi_eeprom_pkg::*;
#(
    parameter int ADDR_BITS   = 10,
    parameter int WR_CYCLES   = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    localparam int AW = ADDR_BITS;

    logic cs_s, sck_s, si_s, hold_s;
    logic cs_d, sck_d;
    logic hold_q;
    logic sck_rise, sck_fall, cs_rise;

    xfer_state_t   st;
    xfer_kind_t    kind;
    logic [4:0]    bit_cnt;
    logic [6:0]    rx_sh;
    logic [7:0]    rx_byte;
    logic [AW-1:0] addr_sh, addr_next;
    logic [AW-1:0] ptr, rd_addr;
    logic [7:0]    tx_sh, rd_data, status, wdata;
    logic [2:0]    tx_cnt;
    logic          so_q, oe_q, wel_q, data_ok;
    logic          busy, commit;

    spi_pin_sync #(
        .W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sck, si, hold_n}),
        .dout ({cs_s, sck_s, si_s, hold_s})
    );

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    // Pause state: changes only while sck is low and the chip is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else if (cs_s) hold_q <= 1'b0;
        else if (!sck_s) hold_q <= !hold_s;
    end

    assign sck_rise  = sck_s & ~sck_d & ~cs_s & ~hold_q;
    assign sck_fall  = ~sck_s & sck_d & ~cs_s & ~hold_q;
    assign cs_rise   = cs_s & ~cs_d;
    assign rx_byte   = {rx_sh, si_s};
    assign addr_next = {addr_sh[AW-2:0], si_s};
    assign rd_addr   = (st == ST_ADDR) ? addr_next : ptr;
    assign status    = {6'b0, wel_q, busy};
    assign commit    = cs_rise & data_ok;

    spi_eeprom_array #(.AW(AW)) i_array (
        .clk  (clk),
        .we   (commit),
        .waddr(ptr),
        .wdata(wdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    spi_eeprom_wtimer #(.CYCLES(WR_CYCLES)) i_wtimer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(commit),
        .busy (busy)
    );

    // Frame engine: shifts in instruction, address and data, shifts out replies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_CMD;
            kind    <= K_NONE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            addr_sh <= '0;
            ptr     <= '0;
            tx_sh   <= '0;
            tx_cnt  <= '0;
            so_q    <= 1'b0;
            oe_q    <= 1'b0;
            wel_q   <= 1'b0;
            wdata   <= '0;
            data_ok <= 1'b0;
        end else if (cs_s) begin
            st      <= ST_CMD;
            kind    <= K_NONE;
            bit_cnt <= '0;
            tx_cnt  <= '0;
            oe_q    <= 1'b0;
            data_ok <= 1'b0;
            if (commit) wel_q <= 1'b0;
        end else begin
            if (sck_rise) begin
                rx_sh <= rx_byte[6:0];
                if (st == ST_CMD || st == ST_ADDR || st == ST_WDATA)
                    bit_cnt <= bit_cnt + 1'b1;
                case (st)
                    ST_CMD: begin
                        if (bit_cnt == 5'd7) begin
                            st <= ST_SKIP;
                            case (rx_byte)
                                OP_READ: begin
                                    if (!busy) begin
                                        st   <= ST_ADDR;
                                        kind <= K_READ;
                                    end
                                end
                                OP_WRITE: begin
                                    if (!busy && wel_q) begin
                                        st   <= ST_ADDR;
                                        kind <= K_WRITE;
                                    end
                                end
                                OP_RDST: begin
                                    st     <= ST_OUT;
                                    kind   <= K_STAT;
                                    tx_sh  <= status;
                                    tx_cnt <= '0;
                                end
                                OP_WEN:  if (!busy) wel_q <= 1'b1;
                                OP_WDIS: if (!busy) wel_q <= 1'b0;
                                default: ;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        addr_sh <= addr_next;
                        if (bit_cnt == 5'd23) begin
                            if (kind == K_READ) begin
                                st     <= ST_OUT;
                                tx_sh  <= rd_data;
                                tx_cnt <= '0;
                                ptr    <= addr_next + 1'b1;
                            end else begin
                                st  <= ST_WDATA;
                                ptr <= addr_next;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (bit_cnt == 5'd31) begin
                            wdata   <= rx_byte;
                            data_ok <= 1'b1;
                            st      <= ST_SKIP;
                        end
                    end
                    ST_SKIP: data_ok <= 1'b0;
                    default: ;
                endcase
            end
            if (sck_fall && st == ST_OUT) begin
                so_q   <= tx_sh[7];
                oe_q   <= 1'b1;
                tx_cnt <= tx_cnt + 1'b1;
                if (tx_cnt == 3'd7) begin
                    tx_sh <= (kind == K_STAT) ? status : rd_data;
                    if (kind == K_READ) ptr <= ptr + 1'b1;
                end else begin
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign so    = so_q;
    assign so_oe = oe_q & ~hold_q;
endmodule

// Protocol checker bound into the slave engine.
module spi_eeprom_slave_chk
    import spi_eeprom_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cs_s,
    input logic        hold_q,
    input logic        so_oe,
    input logic        busy,
    input logic        wel_q,
    input xfer_state_t st,
    input logic [4:0]  bit_cnt
);
    // R5: a deselected chip releases the output on the next cycle.
    p_oe_off_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_oe);

    // R10: no bits are counted while the transfer is paused.
    p_hold_freezes_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && $past(hold_q)) |-> $stable(bit_cnt));

    // R3: the output is only driven in a reply phase.
    p_oe_only_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (st == ST_OUT));

    // R8: the latch is clear once a write cycle has begun.
    p_wel_clear_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !wel_q);

    // R7: a write cycle starts only if the latch was set.
    p_write_needs_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel_q));
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_s   (cs_s),
    .hold_q (hold_q),
    .so_oe  (so_oe),
    .busy   (busy),
    .wel_q  (wel_q),
    .st     (st),
    .bit_cnt(bit_cnt)
);

// File: tb/test_spi_eeprom_slave.sv
module test_spi_eeprom_slave;
    localparam int AB  = 4;
    localparam int WRC = 600;
    localparam int N   = 1 << AB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;
    int   checks = 0, errs = 0;
    logic [7:0] exp_mem [N];

    always #10 clk = ~clk;

    spi_eeprom_slave #(.ADDR_BITS(AB), .WR_CYCLES(WRC), .SYNC_STAGES(2)) i_spi_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_h;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame_begin(input bit m3);
        sck = m3;
        wait_h;
        cs_n = 1'b0;
        wait_h;
    endtask

    task automatic frame_end(input bit m3);
        if (!m3) begin
            sck = 1'b0;
            wait_h;
        end
        cs_n = 1'b1;
        wait_h;
        wait_h;
    endtask

    task automatic xbit(input bit b, output bit o, output bit e);
        sck = 1'b0;
        si  = b;
        wait_h;
        o = so;
        e = so_oe;
        sck = 1'b1;
        wait_h;
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] o,
                         output bit e_any, output bit e_all);
        bit ob, eb;
        e_any = 1'b0;
        e_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xbit(b[i], ob, eb);
            o[i] = ob;
            e_any |= eb;
            e_all &= eb;
        end
    endtask

    task automatic rdst(input bit m3, output logic [7:0] s);
        logic [7:0] o;
        bit ea, el;
        frame_begin(m3);
        xbyte(8'h05, o, ea, el);
        xbyte(8'h00, s, ea, el);
        frame_end(m3);
    endtask

    task automatic cmd1(input logic [7:0] op, input bit m3);
        logic [7:0] o;
        bit ea, el;
        frame_begin(m3);
        xbyte(op, o, ea, el);
        frame_end(m3);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input int nb, input bit m3);
        logic [7:0] o;
        bit ea, el, ob, eb;
        frame_begin(m3);
        xbyte(8'h02, o, ea, el);
        xbyte(a[15:8], o, ea, el);
        xbyte(a[7:0], o, ea, el);
        for (int i = 0; i < nb; i++) xbit(d[7 - (i % 8)], ob, eb);
        frame_end(m3);
    endtask

    task automatic wait_ready;
        logic [7:0] s;
        for (int i = 0; i < 12; i++) begin
            rdst(1'b0, s);
            if (!s[0]) break;
        end
    endtask

    task automatic rd_check(input logic [15:0] a, input int n, input bit m3, input string req);
        logic [7:0] o;
        logic [AB-1:0] idx;
        bit ea, el;
        frame_begin(m3);
        xbyte(8'h03, o, ea, el);
        xbyte(a[15:8], o, ea, el);
        xbyte(a[7:0], o, ea, el);
        idx = a[AB-1:0];
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, o, ea, el);
            chk(o == exp_mem[idx] && el, req, int'(o), int'(exp_mem[idx]));
            idx = idx + 1'b1;
        end
        frame_end(m3);
        chk(so_oe == 1'b0, "R5", int'(so_oe), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] s, o;
        bit ea, el, ob, eb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk(so_oe == 1'b0, "R1", int'(so_oe), 0);
        rdst(1'b0, s);
        chk(s == 8'h00, "R1", int'(s), 0);

        // R7: latch set and clear
        cmd1(8'h06, 1'b1);
        rdst(1'b1, s);
        chk(s == 8'h02, "R7", int'(s), 2);
        cmd1(8'h04, 1'b0);
        rdst(1'b0, s);
        chk(s == 8'h00, "R7", int'(s), 0);

        // R8 R6 R11 R3: fill the array, alternating idle levels, junk upper address bits
        for (int a = 0; a < N; a++) begin
            exp_mem[a] = 8'((a * 53 + 29) & 255);
            cmd1(8'h06, a[0]);
            wr({12'hB7A, 4'(a)}, exp_mem[a], 8, a[0]);
            rdst(a[0], s);
            chk(s == 8'h01, "R8", int'(s), 1);
            wait_ready;
        end
        rdst(1'b0, s);
        chk(s == 8'h00, "R6", int'(s), 0);

        // R7: write with latch clear is ignored
        wr(16'h0005, 8'h00, 8, 1'b0);
        rdst(1'b0, s);
        chk(s == 8'h00, "R7", int'(s), 0);
        rd_check(16'h0005, 1, 1'b0, "R7");

        // R8: wrong bit counts store nothing, latch stays set
        cmd1(8'h06, 1'b0);
        wr(16'h0006, 8'h5A, 9, 1'b0);
        rdst(1'b0, s);
        chk(s == 8'h02, "R8", int'(s), 2);
        wr(16'h0006, 8'h5A, 7, 1'b1);
        rdst(1'b1, s);
        chk(s == 8'h02, "R8", int'(s), 2);
        rd_check(16'h0006, 1, 1'b0, "R8");

        // R9: commands during the busy interval
        wr(16'h0007, 8'h3C, 8, 1'b0);
        exp_mem[7] = 8'h3C;
        cmd1(8'h06, 1'b0);
        frame_begin(1'b0);
        xbyte(8'h03, o, ea, el);
        xbyte(8'h00, o, ea, el);
        xbyte(8'h07, o, ea, el);
        xbyte(8'h00, o, ea, el);
        frame_end(1'b0);
        chk(ea == 1'b0, "R9", int'(ea), 0);
        wait_ready;
        rdst(1'b0, s);
        chk(s == 8'h00, "R9", int'(s), 0);

        // R3 R4 R11: sequential reads from every start, past the top
        for (int st = 0; st < N; st++)
            rd_check({12'h5C3, 4'(st)}, N + 4, st[0], "R4");

        // R6: status repeats while clocked
        frame_begin(1'b1);
        xbyte(8'h05, o, ea, el);
        xbyte(8'h00, o, ea, el);
        xbyte(8'h00, s, ea, el);
        frame_end(1'b1);
        chk(o == 8'h00 && s == 8'h00 && el, "R6", int'(s), 0);

        // R2: every unused instruction leaves the output off
        for (int op = 0; op < 256; op++) begin
            if (op == 3 || op == 2 || op == 5 || op == 6 || op == 4) continue;
            frame_begin(op[0]);
            xbyte(8'(op), o, ea, el);
            xbyte(8'hFF, o, ob, el);
            frame_end(op[0]);
            chk(!(ea || ob), "R2", int'(ea || ob), 0);
        end

        // R10: pause in the middle of a read byte
        frame_begin(1'b0);
        xbyte(8'h03, o, ea, el);
        xbyte(8'h00, o, ea, el);
        xbyte(8'h02, o, ea, el);
        for (int i = 7; i >= 0; i--) begin
            if (i == 4) begin
                sck = 1'b0;
                si = 1'b0;
                wait_h;
                hold_n = 1'b0;
                wait_h;
                chk(so_oe == 1'b0, "R10", int'(so_oe), 0);
                for (int j = 0; j < 2; j++) begin
                    si = ~si;
                    sck = 1'b1;
                    wait_h;
                    sck = 1'b0;
                    wait_h;
                end
                hold_n = 1'b1;
                wait_h;
                o[i] = so;
                sck = 1'b1;
                wait_h;
            end else begin
                xbit(1'b0, ob, eb);
                o[i] = ob;
            end
        end
        chk(o == exp_mem[2], "R10", int'(o), int'(exp_mem[2]));
        xbyte(8'h00, o, ea, el);
        chk(o == exp_mem[3] && el, "R10", int'(o), int'(exp_mem[3]));
        // R5: abandon mid-byte
        sck = 1'b0;
        wait_h;
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(so_oe == 1'b0, "R5", int'(so_oe), 0);
        wait_h;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule